// File: doc/BRIEF.md
# RTC Timekeeping Register Core

This block keeps the time of day and the calendar date in a small byte-addressed register file and moves them forward by one second each time its one-second tick input pulses. Software reaches every byte through a synchronous address/data port. It writes the current time, alarm values and two control bytes, and it reads the time, the update-in-progress indication and a status byte that holds latched event flags.

Two bits of the main control byte set how the time bytes are held. One picks BCD or plain binary. The other picks a 24-hour or 12-hour clock, where the 12-hour clock uses a PM marker in the top bit of the hour byte. All carries ripple from seconds through minutes and hours, then into the day of week and the day of month, then into the month and the year. The month length takes February in leap years into account. A stop bit freezes all updates so that software can load a consistent time. Each completed update latches an update flag. When seconds, minutes and hours all equal their alarm bytes, the update also latches an alarm flag. Each flag can drive an interrupt output through its own enable bit.

Top module: `rtc_core`

## Requirements
- R1: After reset: seconds, minutes, hours and year read 0x00; day of week, day of month and month read 0x01; control A reads 0x00; control B (address 11) reads 0x02; status (address 12) reads 0x00; both interrupt outputs are low.
- R2: A write with `wr_en_i` stores `wdata_i` at `addr_i`. Time bytes are at 0 sec, 1 sec alarm, 2 min, 3 min alarm, 4 hour, 5 hour alarm, 6 day of week, 7 day of month, 8 month, 9 year. Control A is at 10, with bits 6:0 writable and bit 7 read-only. Control B is at 11. `rdata_o` shows the addressed byte on the clock edge that samples `rd_en_i`, and holds it otherwise.
- R3: A tick sampled while control B bit 7 is 0 and no update is pending sets the update-in-progress bit (control A bit 7) at that edge. The advanced time is stored at the next edge, where the bit clears again.
- R4: While control B bit 7 (stop) is 1, ticks are ignored: the time bytes keep their values and no update flag is set.
- R5: Control B bit 2 picks the encoding: 0 is BCD, 1 is binary. Seconds and minutes count 0 to 59 and wrap to 0 with a carry in either encoding.
- R6: With control B bit 1 = 1 (24-hour), hours count 0 to 23. Passing 23 returns to 0 and carries into the day.
- R7: With control B bit 1 = 0 (12-hour), hour bits 6:0 count 12, 1, ..., 11 and bit 7 marks PM. Going from 11 to 12 toggles PM. Only 11 PM to 12 AM carries into the day.
- R8: Day of week counts 1 to 7 and returns to 1 on each day carry.
- R9: Day of month returns to 1 after 31, after 30 for April, June, September and November, and after 28 for February (29 when the binary year is divisible by 4). The wrap advances the month. Month wraps from 12 to 1 and advances the year. Year wraps from 99 to 0.
- R10: Every stored update sets status bit 4. `update_irq_o` is high whenever that flag and control B bit 4 are both set.
- R11: When the advanced seconds, minutes and hours all equal their alarm bytes, the update also sets status bit 5. `alarm_irq_o` is high whenever that flag and control B bit 5 are both set.
- R12: A read of address 12 returns the flags and clears them at the same edge. A flag set at that same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second pulse, one clock wide |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| alarm_irq_o | output | 1 | Alarm interrupt, registered |
| update_irq_o | output | 1 | Update-ended interrupt, registered |

## Verification
Read data is due one edge after the read strobe is sampled. The update-in-progress bit appears at the edge that samples the tick. The new time, both flags and both interrupt outputs are due one edge after that. The bench drives every input on the falling clock edge and samples outputs on the following falling edge. A read issued in the cycle just after the tick pulse therefore observes the in-progress bit, and every later read sees the committed time. Each trial works out the next time, the alarm match and the flag values in bench functions before it pulses the tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam int ADR_SEC   = 0;
  localparam int ADR_SECA  = 1;
  localparam int ADR_MIN   = 2;
  localparam int ADR_MINA  = 3;
  localparam int ADR_HOUR  = 4;
  localparam int ADR_HOURA = 5;
  localparam int ADR_WDAY  = 6;
  localparam int ADR_MDAY  = 7;
  localparam int ADR_MON   = 8;
  localparam int ADR_YEAR  = 9;
  localparam int ADR_CTLA  = 10;
  localparam int ADR_CTLB  = 11;
  localparam int ADR_STAT  = 12;

  localparam int CB_STOP = 7;
  localparam int CB_AIE  = 5;
  localparam int CB_UIE  = 4;
  localparam int CB_BIN  = 2;
  localparam int CB_24H  = 1;
  localparam int ST_AF   = 5;
  localparam int ST_UF   = 4;

  localparam byte_t CTLB_RESET = 8'h02;

  // counting fields handled by the generic incrementer
  localparam int NUM_CNT = 6;
  localparam int CI_SEC = 0, CI_MIN = 1, CI_WDAY = 2, CI_MDAY = 3, CI_MON = 4, CI_YEAR = 5;

  function automatic int cnt_addr(input int i);
    case (i)
      CI_SEC:  return ADR_SEC;
      CI_MIN:  return ADR_MIN;
      CI_WDAY: return ADR_WDAY;
      CI_MDAY: return ADR_MDAY;
      CI_MON:  return ADR_MON;
      default: return ADR_YEAR;
    endcase
  endfunction

  function automatic byte_t cnt_lo(input int i);
    case (i)
      CI_WDAY, CI_MDAY, CI_MON: return 8'd1;
      default:                  return 8'd0;
    endcase
  endfunction

  function automatic byte_t cnt_hi(input int i);
    case (i)
      CI_SEC, CI_MIN: return 8'd59;
      CI_WDAY:        return 8'd7;
      CI_MDAY:        return 8'd31;
      CI_MON:         return 8'd12;
      default:        return 8'd99;
    endcase
  endfunction

  function automatic byte_t bcd_to_bin(input byte_t b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction

  function automatic byte_t bin_to_bcd(input byte_t v);
    byte_t tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction
endpackage

// File: rtl/rtc_field_inc.sv
module rtc_field_inc
  import rtc_pkg::*;
(
  input  byte_t val_i,
  input  logic  bin_i,
  input  byte_t lo_i,
  input  byte_t hi_i,
  output byte_t nxt_o,
  output logic  wrap_o
);
  byte_t cur, nb;

  always_comb begin
    cur    = bin_i ? val_i : bcd_to_bin(val_i);
    wrap_o = (cur >= hi_i);
    nb     = wrap_o ? lo_i : cur + 8'd1;
    nxt_o  = bin_i ? nb : bin_to_bcd(nb);
  end
endmodule

// File: rtl/rtc_hour_inc.sv
module rtc_hour_inc
  import rtc_pkg::*;
(
  input  byte_t val_i,
  input  logic  bin_i,
  input  logic  h24_i,
  output byte_t nxt_o,
  output logic  carry_o
);
  byte_t cur24, cur12, nb, enc;
  logic  pm, pm_n;

  always_comb begin
    cur24   = bin_i ? val_i : bcd_to_bin(val_i);
    cur12   = bin_i ? {1'b0, val_i[6:0]} : bcd_to_bin({1'b0, val_i[6:0]});
    pm      = val_i[7];
    pm_n    = pm;
    carry_o = 1'b0;
    if (h24_i) begin
      if (cur24 >= 8'd23) begin
        nb      = 8'd0;
        carry_o = 1'b1;
      end else begin
        nb = cur24 + 8'd1;
      end
    end else begin
      if (cur12 >= 8'd12) begin
        nb = 8'd1;
      end else if (cur12 == 8'd11) begin
        nb      = 8'd12;
        pm_n    = ~pm;
        carry_o = pm;
      end else begin
        nb = cur12 + 8'd1;
      end
    end
    enc   = bin_i ? nb : bin_to_bcd(nb);
    nxt_o = h24_i ? enc : {pm_n, enc[6:0]};
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  byte_t mon_i,
  input  byte_t year_i,
  input  logic  bin_i,
  output byte_t last_o
);
  byte_t m, y;

  always_comb begin
    m = bin_i ? mon_i  : bcd_to_bin(mon_i);
    y = bin_i ? year_i : bcd_to_bin(year_i);
    case (m)
      8'd2:                   last_o = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: last_o = 8'd30;
      default:                last_o = 8'd31;
    endcase
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_TIME = 10
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              alarm_irq_o,
  output logic              update_irq_o
);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(ADR_CTLA);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(ADR_CTLB);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

  byte_t       tr_q   [NUM_TIME];
  byte_t       next_t [NUM_TIME];
  logic [6:0]  rega_q;
  byte_t       regb_q, regb_d;
  logic        busy_q, commit, stop, bin_mode;
  logic        uf_q, af_q, uf_d, af_d, stat_clr, alarm_hit;
  logic        time_wr;
  byte_t       rd_val, mday_last, hour_nxt;
  logic        hour_carry;
  byte_t       inc_nxt [NUM_CNT];
  logic [NUM_CNT-1:0] inc_wrap;

  assign stop     = regb_q[CB_STOP];
  assign bin_mode = regb_q[CB_BIN];
  assign commit   = busy_q & ~stop;
  assign time_wr  = wr_en_i && (int'(addr_i) < NUM_TIME);

  // ---------------- increment datapath ----------------
  rtc_month_len u_mlen (
    .mon_i  (tr_q[ADR_MON]),
    .year_i (tr_q[ADR_YEAR]),
    .bin_i  (bin_mode),
    .last_o (mday_last)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam int FA = cnt_addr(g);
    byte_t hi;
    if (g == CI_MDAY) begin : g_dyn
      assign hi = mday_last;
    end else begin : g_fix
      assign hi = cnt_hi(g);
    end
    rtc_field_inc u_inc (
      .val_i  (tr_q[FA]),
      .bin_i  (bin_mode),
      .lo_i   (cnt_lo(g)),
      .hi_i   (hi),
      .nxt_o  (inc_nxt[g]),
      .wrap_o (inc_wrap[g])
    );
  end

  rtc_hour_inc u_hour (
    .val_i   (tr_q[ADR_HOUR]),
    .bin_i   (bin_mode),
    .h24_i   (regb_q[CB_24H]),
    .nxt_o   (hour_nxt),
    .carry_o (hour_carry)
  );

  always_comb begin
    for (int i = 0; i < NUM_TIME; i++) next_t[i] = tr_q[i];
    next_t[ADR_SEC] = inc_nxt[CI_SEC];
    if (inc_wrap[CI_SEC]) begin
      next_t[ADR_MIN] = inc_nxt[CI_MIN];
      if (inc_wrap[CI_MIN]) begin
        next_t[ADR_HOUR] = hour_nxt;
        if (hour_carry) begin
          next_t[ADR_WDAY] = inc_nxt[CI_WDAY];
          next_t[ADR_MDAY] = inc_nxt[CI_MDAY];
          if (inc_wrap[CI_MDAY]) begin
            next_t[ADR_MON] = inc_nxt[CI_MON];
            if (inc_wrap[CI_MON]) next_t[ADR_YEAR] = inc_nxt[CI_YEAR];
          end
        end
      end
    end
  end

  assign alarm_hit = (next_t[ADR_SEC]  == tr_q[ADR_SECA]) &&
                     (next_t[ADR_MIN]  == tr_q[ADR_MINA]) &&
                     (next_t[ADR_HOUR] == tr_q[ADR_HOURA]);

  // ---------------- flags and control next-state ----------------
  assign stat_clr = rd_en_i && (addr_i == A_STAT);
  assign uf_d     = (uf_q & ~stat_clr) | commit;
  assign af_d     = (af_q & ~stat_clr) | (commit & alarm_hit);
  assign regb_d   = (wr_en_i && addr_i == A_CTLB) ? wdata_i : regb_q;

  always_comb begin
    if (int'(addr_i) < NUM_TIME) begin
      rd_val = tr_q[addr_i];
    end else begin
      case (addr_i)
        A_CTLA:  rd_val = {busy_q, rega_q};
        A_CTLB:  rd_val = regb_q;
        A_STAT:  rd_val = {2'b00, af_q, uf_q, 4'b0000};
        default: rd_val = '0;
      endcase
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TIME; i++) tr_q[i] <= '0;
      tr_q[ADR_WDAY] <= 8'd1;
      tr_q[ADR_MDAY] <= 8'd1;
      tr_q[ADR_MON]  <= 8'd1;
      rega_q       <= '0;
      regb_q       <= CTLB_RESET;
      busy_q       <= 1'b0;
      uf_q         <= 1'b0;
      af_q         <= 1'b0;
      rdata_o      <= '0;
      alarm_irq_o  <= 1'b0;
      update_irq_o <= 1'b0;
    end else begin
      busy_q <= tick_i & ~stop & ~busy_q;
      if (commit) begin
        for (int i = 0; i < NUM_TIME; i++) tr_q[i] <= next_t[i];
      end
      if (time_wr) tr_q[addr_i] <= wdata_i;
      if (wr_en_i && addr_i == A_CTLA) rega_q <= wdata_i[6:0];
      regb_q       <= regb_d;
      uf_q         <= uf_d;
      af_q         <= af_d;
      update_irq_o <= uf_d & regb_d[CB_UIE];
      alarm_irq_o  <= af_d & regb_d[CB_AIE];
      if (rd_en_i) rdata_o <= rd_val;
    end
  end

  // ---------------- assertions ----------------
  p_uip_single_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);

  p_tick_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !stop && !busy_q) |=> busy_q);

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_en_i) |=> ($stable(tr_q[ADR_SEC]) && $stable(tr_q[ADR_MIN]) &&
                            $stable(tr_q[ADR_HOUR]) && $stable(tr_q[ADR_MDAY])));

  p_uf_set_r10: assert property (@(posedge clk) disable iff (rst)
    commit |=> uf_q);

  p_uirq_needs_flag_r10: assert property (@(posedge clk) disable iff (rst)
    update_irq_o |-> uf_q);

  p_alarm_set_r11: assert property (@(posedge clk) disable iff (rst)
    (commit && alarm_hit) |=> af_q);

  p_read_clears_r12: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !commit) |=> (!uf_q && !af_q));
endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_irq, update_irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_core u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .alarm_irq_o(alarm_irq), .update_irq_o(update_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = 4'(a);
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  function automatic logic [7:0] enc(input int v, input bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] henc(input int h, input bit bin, input bit h24);
    logic [7:0] e;
    int h12;
    if (h24) return enc(h, bin);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    e = enc(h12, bin);
    return {(h >= 12), e[6:0]};
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // one trial: load time, tick once, compare the advanced time and flags
  task automatic trial(input int s, m, h, wd, md, mo, yr,
                       input bit bin, h24, aie, uie, hit);
    logic [7:0] ctl, v;
    int ns, nm, nh, nwd, nmd, nmo, nyr;
    ctl = {2'b00, aie, uie, 1'b0, bin, h24, 1'b0};
    ns = s + 1; nm = m; nh = h; nwd = wd; nmd = md; nmo = mo; nyr = yr;
    if (ns == 60) begin
      ns = 0; nm++;
      if (nm == 60) begin
        nm = 0; nh++;
        if (nh == 24) begin
          nh = 0;
          nwd = (wd == 7) ? 1 : wd + 1;
          nmd++;
          if (nmd > mlen(mo, yr)) begin
            nmd = 1; nmo++;
            if (nmo == 13) begin nmo = 1; nyr = (yr + 1) % 100; end
          end
        end
      end
    end
    wr(11, ctl | 8'h80);
    wr(0, enc(s, bin)); wr(2, enc(m, bin)); wr(4, henc(h, bin, h24));
    wr(6, enc(wd, bin)); wr(7, enc(md, bin)); wr(8, enc(mo, bin)); wr(9, enc(yr, bin));
    wr(1, hit ? enc(ns, bin) : 8'hFF);
    wr(3, hit ? enc(nm, bin) : 8'hFF);
    wr(5, hit ? henc(nh, bin, h24) : 8'hFF);
    rd(12, v);
    wr(11, ctl);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; rd_en = 1; addr = 4'd10;
    @(negedge clk); rd_en = 0;
    check("R3 uip during update", {7'b0, rdata[7]}, 8'h01);
    check("R10 update_irq", {7'b0, update_irq}, {7'b0, uie});
    check("R11 alarm_irq", {7'b0, alarm_irq}, {7'b0, (hit & aie)});
    rd(10, v); check("R3 uip cleared", {7'b0, v[7]}, 8'h00);
    rd(0, v);  check("R5 seconds", v, enc(ns, bin));
    rd(2, v);  check("R5 minutes", v, enc(nm, bin));
    rd(4, v);  check(h24 ? "R6 hours" : "R7 hours", v, henc(nh, bin, h24));
    rd(6, v);  check("R8 day of week", v, enc(nwd, bin));
    rd(7, v);  check("R9 day of month", v, enc(nmd, bin));
    rd(8, v);  check("R9 month", v, enc(nmo, bin));
    rd(9, v);  check("R9 year", v, enc(nyr, bin));
    rd(12, v); check("R11 R10 status flags", v, {2'b00, hit, 1'b1, 4'b0000});
    rd(12, v); check("R12 flags cleared by read", v, 8'h00);
    check("R12 irqs low after clear", {6'b0, alarm_irq, update_irq}, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 alarm_irq reset", {7'b0, alarm_irq}, 8'h00);
    check("R1 update_irq reset", {7'b0, update_irq}, 8'h00);
    rd(0, v);  check("R1 seconds reset", v, 8'h00);
    rd(4, v);  check("R1 hours reset", v, 8'h00);
    rd(6, v);  check("R1 wday reset", v, 8'h01);
    rd(7, v);  check("R1 mday reset", v, 8'h01);
    rd(8, v);  check("R1 month reset", v, 8'h01);
    rd(9, v);  check("R1 year reset", v, 8'h00);
    rd(10, v); check("R1 ctl A reset", v, 8'h00);
    rd(11, v); check("R1 ctl B reset", v, 8'h02);
    rd(12, v); check("R1 status reset", v, 8'h00);

    // R2: register access, control A bit 7 not writable
    wr(10, 8'hA6); rd(10, v); check("R2 ctl A write/read", v, 8'h26);
    wr(3, 8'h42);  rd(3, v);  check("R2 alarm byte write/read", v, 8'h42);
    wr(11, 8'h02); rd(11, v); check("R2 ctl B write/read", v, 8'h02);

    // R4: stop bit freezes updates
    wr(11, 8'h82); wr(0, 8'h30);
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    repeat (3) @(negedge clk);
    rd(0, v);  check("R4 seconds frozen", v, 8'h30);
    rd(12, v); check("R4 no update flag", v, 8'h00);
    wr(11, 8'h02);

    // directed corners
    trial(59, 59, 23, 7, 31, 12, 99, 0, 1, 1, 1, 1); // full wrap, BCD 24h
    trial(59, 59, 23, 3, 28, 2, 4,  1, 1, 0, 1, 0);  // leap February
    trial(59, 59, 23, 3, 28, 2, 5,  1, 1, 0, 1, 0);  // common February
    trial(59, 59, 23, 2, 30, 4, 21, 0, 1, 1, 0, 1);  // 30-day month
    trial(59, 59, 11, 1, 10, 6, 30, 0, 0, 1, 1, 1);  // 11 AM -> 12 PM
    trial(59, 59, 23, 5, 10, 6, 30, 1, 0, 1, 1, 0);  // 11 PM -> 12 AM, day carry
    trial(59, 59, 12, 5, 10, 6, 30, 0, 0, 0, 1, 0);  // 12 PM -> 1 PM
    trial(59, 59, 0,  5, 10, 6, 30, 1, 0, 0, 0, 1);  // 12 AM -> 1 AM
    trial(9, 0, 5, 1, 1, 1, 0, 0, 1, 0, 0, 0);       // BCD digit carry 09 -> 10

    // constrained random
    for (int t = 0; t < 40; t++) begin
      int s, m, h, wd, md, mo, yr;
      mo = 1 + int'($urandom % 12);
      yr = int'($urandom % 100);
      md = ($urandom % 2) ? mlen(mo, yr) : 1 + int'($urandom % mlen(mo, yr));
      s  = ($urandom % 2) ? 59 : int'($urandom % 60);
      m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      wd = 1 + int'($urandom % 7);
      trial(s, m, h, wd, md, mo, yr, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
    end
    summary();
  end
endmodule